// File: doc/BRIEF.md
# Per-Line GPIO Interrupt Detector

This block turns a set of already synchronized input lines into interrupt events. Software picks, for each line on its own, whether the line interrupts on a level or on an edge, which polarity counts, and whether both edges count. Level events follow the pin and are never stored. Edge events are latched until software clears them by writing ones to a clear strobe.

The block offers two status views. The raw view shows every detected event whatever the enables are. The masked view is the raw view gated by a per-line enable. One interrupt request is the OR of the masked view. Register decode and pad synchronizers sit upstream, so the block sees only write strobes with a shared data word, the synchronized lines, and the two status words.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the sense, both-edges, polarity and enable registers are all 0, every latched edge bit is 0, `raw_status` and `masked_status` read 0 and `irq` is 0.
- R2: A line whose sense bit is 1 is level sensitive. Its raw bit is 1 exactly while the pin equals its polarity bit (1 = active high, 0 = active low). The bit follows the pin combinationally in the same cycle and is never latched.
- R3: A line whose sense bit is 0 and whose both-edges bit is 0 is edge sensitive. Polarity 1 selects a rising edge and polarity 0 a falling edge. An edge is found by comparing the pin with its value at the previous clock edge. The raw bit becomes 1 after the clock edge that samples the change, and it stays 1.
- R4: A line with sense 0 and both-edges 1 latches on either transition, and its polarity bit has no effect.
- R5: `masked_status` equals `raw_status` AND the enable register, bit for bit.
- R6: `irq` is 1 exactly while some bit of `masked_status` is 1.
- R7: A cycle with `wr_clear` high clears, at that clock edge, each latched edge bit whose `wr_data` bit is 1. Bits written as 0 keep their value.
- R8: If an edge is detected on a line in the same cycle that the line is cleared, the bit is set after that edge.
- R9: With the enable bit at 0, edge events are still latched in `raw_status`. Setting the enable later raises `irq` without any new edge.
- R10: Writing the sense, both-edges or polarity registers does not clear latched edge bits.
- R11: Each of `wr_sense`, `wr_both`, `wr_pol` and `wr_enable` loads `wr_data` into its register at the clock edge where the strobe is high. The new setting governs detection from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_sync | input | N_LINES | Synchronized input lines |
| wr_sense | input | 1 | Load the sense register (1 = level) from `wr_data` |
| wr_both | input | 1 | Load the both-edges register from `wr_data` |
| wr_pol | input | 1 | Load the polarity register from `wr_data` |
| wr_enable | input | 1 | Load the enable register from `wr_data` |
| wr_clear | input | 1 | Clear the latched edge bits set in `wr_data` |
| wr_data | input | N_LINES | Write data shared by all strobes |
| raw_status | output | N_LINES | Raw event status |
| masked_status | output | N_LINES | Raw status gated by the enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the default of eight lines. With eight lines, random 8-bit configuration words put level-high, level-low, rising, falling and both-edge lines side by side in the same cycle, and bits may be enabled or not. Random clear words land together with edges often enough to exercise the case where a clear and a new edge hit the same bit. Directed sequences also cover reset, a level bit that drops at once, a late enable, and a configuration write over latched bits.

// File: rtl/gid_pkg.sv
package gid_pkg;

  typedef struct packed {
    logic level;   // 1: level sensing, 0: edge sensing
    logic both;    // edge mode: any transition
    logic pol;     // 1: high / rising, 0: low / falling
  } line_cfg_t;

  // Edge event between the previous and the current sample.
  function automatic logic edge_event(input logic prev, input logic cur,
                                      input line_cfg_t cfg);
    logic rise;
    logic fall;
    rise = ~prev & cur;
    fall = prev & ~cur;
    if (cfg.level)
      return 1'b0;
    else if (cfg.both)
      return rise | fall;
    else
      return cfg.pol ? rise : fall;
  endfunction

  // Level condition: pin sits at the selected level.
  function automatic logic level_active(input logic cur, input line_cfg_t cfg);
    return cfg.level & ~(cur ^ cfg.pol);
  endfunction

endpackage

// File: rtl/gid_cfg_bank.sv
module gid_cfg_bank #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_sense,
  input  logic               wr_both,
  input  logic               wr_pol,
  input  logic               wr_enable,
  input  logic [N_LINES-1:0] wr_data,
  output logic [N_LINES-1:0] sense_q,
  output logic [N_LINES-1:0] both_q,
  output logic [N_LINES-1:0] pol_q,
  output logic [N_LINES-1:0] enable_q
);

  localparam int N_REGS = 4;

  logic [N_REGS-1:0]              strobe;
  logic [N_REGS-1:0][N_LINES-1:0] bank_q;

  assign strobe = {wr_enable, wr_pol, wr_both, wr_sense};

  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[r] <= '0;
      else if (strobe[r])
        bank_q[r] <= wr_data;
    end
  end

  assign sense_q  = bank_q[0];
  assign both_q   = bank_q[1];
  assign pol_q    = bank_q[2];
  assign enable_q = bank_q[3];

endmodule

// File: rtl/gid_line_det.sv
module gid_line_det
  import gid_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin,
  input  line_cfg_t cfg,
  input  logic      clr,
  output logic      hit,
  output logic      latched,
  output logic      raw
);

  logic prev_q;
  logic lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prev_q <= 1'b0;
    else
      prev_q <= pin;
  end

  assign hit = edge_event(prev_q, pin, cfg);

  // A new edge has priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lat_q <= 1'b0;
    else
      lat_q <= hit | (lat_q & ~clr);
  end

  assign latched = lat_q;
  assign raw     = cfg.level ? level_active(pin, cfg) : lat_q;

endmodule

// File: rtl/gid_combine.sv
module gid_combine #(
  parameter int N_LINES = 8
) (
  input  logic [N_LINES-1:0] raw,
  input  logic [N_LINES-1:0] enable,
  output logic [N_LINES-1:0] masked,
  output logic               any
);

  assign masked = raw & enable;
  assign any    = |masked;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gid_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pin_sync,
  input  logic               wr_sense,
  input  logic               wr_both,
  input  logic               wr_pol,
  input  logic               wr_enable,
  input  logic               wr_clear,
  input  logic [N_LINES-1:0] wr_data,
  output logic [N_LINES-1:0] raw_status,
  output logic [N_LINES-1:0] masked_status,
  output logic               irq
);

  logic [N_LINES-1:0] sense_q;
  logic [N_LINES-1:0] both_q;
  logic [N_LINES-1:0] pol_q;
  logic [N_LINES-1:0] enable_q;
  logic [N_LINES-1:0] clr_vec;
  logic [N_LINES-1:0] hit_vec;
  logic [N_LINES-1:0] edge_lat;

  gid_cfg_bank #(.N_LINES(N_LINES)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sense  (wr_sense),
    .wr_both   (wr_both),
    .wr_pol    (wr_pol),
    .wr_enable (wr_enable),
    .wr_data   (wr_data),
    .sense_q   (sense_q),
    .both_q    (both_q),
    .pol_q     (pol_q),
    .enable_q  (enable_q)
  );

  assign clr_vec = wr_clear ? wr_data : '0;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    line_cfg_t cfg;
    assign cfg = '{level: sense_q[i], both: both_q[i], pol: pol_q[i]};

    gid_line_det u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (pin_sync[i]),
      .cfg     (cfg),
      .clr     (clr_vec[i]),
      .hit     (hit_vec[i]),
      .latched (edge_lat[i]),
      .raw     (raw_status[i])
    );
  end

  gid_combine #(.N_LINES(N_LINES)) u_comb (
    .raw    (raw_status),
    .enable (enable_q),
    .masked (masked_status),
    .any    (irq)
  );

endmodule

module gid_checker #(
  parameter int N_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] pin_sync,
  input logic [N_LINES-1:0] sense_q,
  input logic [N_LINES-1:0] pol_q,
  input logic [N_LINES-1:0] enable_q,
  input logic [N_LINES-1:0] clr_vec,
  input logic [N_LINES-1:0] hit_vec,
  input logic [N_LINES-1:0] edge_lat,
  input logic [N_LINES-1:0] raw_status,
  input logic [N_LINES-1:0] masked_status,
  input logic               irq
);

  // R2: level lines mirror the pin against the polarity
  a_r2_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status & sense_q) == (~(pin_sync ^ pol_q) & sense_q));

  // R5: no masked bit without its enable
  a_r5_masked_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_status & ~enable_q) == '0);

  // R6: request tracks the masked word
  a_r6_irq_any: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (masked_status != '0));

  // R7: a clear without a new edge empties the bit
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (edge_lat & $past(clr_vec & ~hit_vec)) == '0);

  // R8: a detected edge is latched, even against a clear
  a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (edge_lat & $past(hit_vec)) == $past(hit_vec));

  // R10: without edge or clear the latch holds, config writes included
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec == '0 && clr_vec == '0) |=> $stable(edge_lat));

endmodule

bind gpio_irq_detect gid_checker #(.N_LINES(N_LINES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pin_sync      (pin_sync),
  .sense_q       (sense_q),
  .pol_q         (pol_q),
  .enable_q      (enable_q),
  .clr_vec       (clr_vec),
  .hit_vec       (hit_vec),
  .edge_lat      (edge_lat),
  .raw_status    (raw_status),
  .masked_status (masked_status),
  .irq           (irq)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0;
  logic         ws = 0, wb = 0, wp = 0, we = 0, wc = 0;
  logic [N-1:0] wd = '0;
  logic [N-1:0] raw, msk;
  logic         irq;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic [N-1:0] m_sense = '0, m_both = '0, m_pol = '0, m_en = '0;
  logic [N-1:0] m_lat = '0, m_prev = '0;

  always #2.5 clk = ~clk;

  gpio_irq_detect #(.N_LINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin),
    .wr_sense(ws), .wr_both(wb), .wr_pol(wp), .wr_enable(we),
    .wr_clear(wc), .wr_data(wd),
    .raw_status(raw), .masked_status(msk), .irq(irq)
  );

  // expected raw word, evaluated bit by bit
  function automatic logic [N-1:0] exp_raw(input logic [N-1:0] p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (m_sense[i]) r[i] = (p[i] == m_pol[i]);
      else            r[i] = m_lat[i];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_hits(input logic [N-1:0] old_p,
                                            input logic [N-1:0] new_p);
    logic [N-1:0] h;
    for (int i = 0; i < N; i++) begin
      if (m_sense[i])              h[i] = 1'b0;
      else if (old_p[i] == new_p[i]) h[i] = 1'b0;
      else if (m_both[i])          h[i] = 1'b1;
      else                         h[i] = (new_p[i] == m_pol[i]);
    end
    return h;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [N-1:0] er;
    er = exp_raw(pin);
    chk("R2 level lines", raw & m_sense, er & m_sense);
    chk("R3 single-edge lines", raw & ~m_sense & ~m_both, er & ~m_sense & ~m_both);
    chk("R4 both-edge lines", raw & ~m_sense & m_both, er & ~m_sense & m_both);
    chk("R5 masked", msk, er & m_en);
    chk("R6 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(er & m_en)});
  endtask

  // inputs are set before the call (at a falling edge)
  task automatic tick();
    logic [N-1:0] h;
    @(posedge clk);
    h = exp_hits(m_prev, pin);
    m_lat = h | (m_lat & ~(wc ? wd : '0));
    if (ws) m_sense = wd;
    if (wb) m_both  = wd;
    if (wp) m_pol   = wd;
    if (we) m_en    = wd;
    m_prev = pin;
    @(negedge clk);
    ws = 0; wb = 0; wp = 0; we = 0; wc = 0;
    compare_all();
  endtask

  task automatic wr(input int sel, input logic [N-1:0] d);
    wd = d;
    case (sel)
      0: ws = 1;
      1: wb = 1;
      2: wp = 1;
      3: we = 1;
      default: wc = 1;
    endcase
    tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 raw", raw, '0);
    chk("R1 masked", msk, '0);
    chk("R1 irq", {{(N-1){1'b0}}, irq}, '0);
    pin = 8'hFF; tick();     // rising everywhere, falling-edge default: nothing
    chk("R1 defaults falling-edge", raw, '0);

    // R11 configuration: line0 level high, line1 level low, line2 rising,
    // line3 falling, line4 both, others falling; enables all
    wr(3, 8'hFF);
    wr(0, 8'h03);
    wr(2, 8'h05);
    wr(1, 8'h10);
    pin = 8'h00; tick();     // falling on 3..7 (and 4 via both)
    chk("R3 falling latched", raw & 8'hF8, 8'hF8);
    chk("R2 level low active", raw & 8'h03, 8'h02);
    // R2 combinational, not latched
    pin = 8'h01; #1;
    chk("R2 same-cycle follow", raw & 8'h03, 8'h03);
    pin = 8'h00; #1;
    chk("R2 drops at once", raw & 8'h01, 8'h00);
    tick();
    // R7 clear bits 3..7 except 5; bit written 0 keeps value
    wr(4, 8'hD8);
    chk("R7 clear with 0 keeps bit", raw & 8'hF8, 8'h20);
    wr(4, 8'h20);
    chk("R7 cleared", raw & 8'hFC, 8'h00);
    // R3 rising on line2, R4 rising on line4
    pin = 8'h14; tick();
    chk("R3 rising line2", raw[2], 1'b1);
    chk("R4 rising line4", raw[4], 1'b1);
    wr(4, 8'h10);
    // R4 falling on line4 while its polarity is 1
    wr(2, 8'h15);
    pin = 8'h04; tick();
    chk("R4 falling ignores polarity", raw[4], 1'b1);
    // R8 edge and clear together on line4
    pin = 8'h14; wd = 8'h10; wc = 1; tick();
    chk("R8 edge beats clear", raw[4], 1'b1);
    // R10 config write keeps latched bits
    wr(2, 8'h00);
    wr(1, 8'h00);
    chk("R10 latch survives config", raw & 8'h14, 8'h14);
    // R9 enable 0 still records
    wr(4, 8'hFF);
    wr(3, 8'h00);
    pin = 8'h00; tick();     // falling on 2,4
    chk("R9 raw records while disabled", raw & 8'h14, 8'h14);
    chk("R9 irq low while disabled", {{(N-1){1'b0}}, irq}, '0);
    wr(3, 8'h10);
    chk("R9 late enable raises irq", {{(N-1){1'b0}}, irq}, 8'h01);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      int k;
      pin = N'($urandom);
      k = $urandom_range(0, 15);
      wd = N'($urandom);
      if (k < 5) begin
        case (k)
          0: ws = 1;
          1: wb = 1;
          2: wp = 1;
          3: we = 1;
          default: wc = 1;
        endcase
      end else if (k < 8) begin
        wc = 1;
      end
      tick();
    end
    finish_run();
  end

endmodule